// File: doc/BRIEF.md
# Masked SIMD Processing-Element Array

This block is a lock-step array of processing elements fed by one broadcast instruction stream. Each element owns a private word memory, one accumulator and one receive register. A single mode bit per element decides whether that element carries out the broadcast instruction. Inactive elements keep their state exactly as it was. Arithmetic works on one full word, on two independent half-word lanes or on eight independent byte lanes, and no carry crosses a lane boundary.

A control unit outside the block issues one instruction per cycle. The instruction can be a local load or store, a lane-wise add, a bitwise logic operation, a mode update, or a halving transfer that supports tree reductions. For a vector add, every active element loads its accumulator from base+1, adds the word at base+2 and stores the sum at base. A reduction repeats one step at spans N, N/2, and so on: move the upper half of the accumulators into the lower half's receive registers, then add them. The element count is a power-of-two parameter.

The default configuration is 8 elements with 32 words each, which keeps elaboration small. Element count, word width, memory depth and field widths all scale through parameters.

Top module: `simd_pe_array`

## Requirements
- R1: During and after reset, every accumulator and receive register reads zero and every mode bit is 1 (all elements active).
- R2: An instruction is sampled on the rising edge where `instr_valid` is high. Its effect appears on `acc_flat` and `mode_bits` after the next rising edge, and not before.
- R3: Opcode 1 (load) copies local memory word `instr_addr` into the accumulator. Opcode 2 (store) writes the accumulator to local word `instr_addr`. Opcode 11 (immediate) copies `bcast_word` into the accumulator. Only the low log2(depth) address bits select the word.
- R4: An element whose mode bit is 0 when an instruction executes leaves its accumulator, receive register and memory unchanged.
- R5: Opcode 3 adds the memory word to the accumulator. Format 0 (and reserved format 3) adds one 64-bit value. Format 1 adds two 32-bit lanes (bits 31:0 and 63:32). Format 2 adds eight 8-bit lanes (byte k at bits 8k+7:8k). Each lane wraps on its own.
- R6: Opcodes 4, 5 and 6 replace the accumulator with its bitwise AND, OR and XOR with the memory word.
- R7: Opcode 7 loads mode bit i of element i from bit i of `bcast_word`.
- R8: Opcode 8 clears the mode bit of every element whose index is at or above `instr_opnd` and never sets a mode bit.
- R9: Opcode 9 with span N copies the accumulator of element i+N/2 into the receive register of each active element i with i < N/2. Opcode 10 adds the receive register to the accumulator using the lane rules of R5.
- R10: Opcode 0, opcodes 12 to 15, and any cycle with `instr_valid` low change no accumulator and no mode bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Broadcast instruction present this cycle |
| instr_op | input | 4 | Opcode |
| instr_fmt | input | 2 | Lane format: 0 word, 1 two halves, 2 eight bytes |
| instr_addr | input | ADDR_W (11) | Local memory address |
| instr_opnd | input | OPND_W (7) | Span or element-index operand |
| bcast_word | input | WORD_W (64) | Broadcast mode mask or immediate |
| acc_flat | output | NUM_PE*WORD_W | Accumulators, element i at bits i*WORD_W upward |
| mode_bits | output | NUM_PE | Current mode bit per element |

## Verification
Every result is due exactly two rising edges after the instruction is presented: the first edge samples the instruction and reads memory, and the second edge writes the accumulator, receive register, memory or mode bits. The bench drives each instruction at a falling edge and checks all state at the next falling edge, where nothing may have changed yet. It then checks the full expected state at the falling edge after that. Memory contents are read back through loads, so every stored word is compared against the bench's reference model after the vector-add, masked, logic and reduction sequences.

// File: rtl/simd_pe_pkg.sv
package simd_pe_pkg;

   typedef enum logic [3:0] {
      OP_NOP      = 4'd0,
      OP_LOAD     = 4'd1,
      OP_STORE    = 4'd2,
      OP_ADD      = 4'd3,
      OP_AND      = 4'd4,
      OP_OR       = 4'd5,
      OP_XOR      = 4'd6,
      OP_SETMODE  = 4'd7,
      OP_CLRABOVE = 4'd8,
      OP_HALVE    = 4'd9,
      OP_ADDRCV   = 4'd10,
      OP_LDIMM    = 4'd11
   } pe_op_e;

   typedef enum logic [1:0] {
      FMT_W64  = 2'd0,
      FMT_W32  = 2'd1,
      FMT_W8   = 2'd2,
      FMT_RSVD = 2'd3
   } pe_fmt_e;

endpackage

// File: rtl/pe_lane_adder.sv
module pe_lane_adder
   import simd_pe_pkg::*;
#(
   parameter int WORD_W = 64
) (
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   input  logic [1:0]        fmt,
   output logic [WORD_W-1:0] sum
);
   localparam int HALF_W = WORD_W / 2;
   localparam int BYTE_W = WORD_W / 8;

   if (WORD_W % 16 != 0) begin : g_bad_width
      $error("pe_lane_adder: WORD_W must be a multiple of 16");
   end

   logic [WORD_W-1:0] s_full, s_half, s_byte;

   assign s_full = a + b;

   for (genvar h = 0; h < 2; h++) begin : g_half
      assign s_half[h*HALF_W +: HALF_W] = a[h*HALF_W +: HALF_W] + b[h*HALF_W +: HALF_W];
   end

   for (genvar k = 0; k < 8; k++) begin : g_byte
      assign s_byte[k*BYTE_W +: BYTE_W] = a[k*BYTE_W +: BYTE_W] + b[k*BYTE_W +: BYTE_W];
   end

   always_comb begin
      case (fmt)
         FMT_W32: sum = s_half;
         FMT_W8:  sum = s_byte;
         default: sum = s_full;
      endcase
   end

endmodule

// File: rtl/pe_element.sv
module pe_element
   import simd_pe_pkg::*;
#(
   parameter int WORD_W    = 64,
   parameter int MEM_DEPTH = 32,
   parameter int MEM_AW    = $clog2(MEM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MEM_AW-1:0] rd_addr,
   input  logic              ex_active,
   input  logic [3:0]        ex_op,
   input  logic [1:0]        ex_fmt,
   input  logic [MEM_AW-1:0] ex_addr,
   input  logic              ex_recv_sel,
   input  logic [WORD_W-1:0] recv_in,
   input  logic [WORD_W-1:0] imm,
   output logic [WORD_W-1:0] acc_out
);
   logic [WORD_W-1:0] mem [MEM_DEPTH];
   logic [WORD_W-1:0] rd_q, acc_q, recv_q, b_opnd, lane_sum;

   assign b_opnd = (ex_op == OP_ADDRCV) ? recv_q : rd_q;

   pe_lane_adder #(.WORD_W(WORD_W)) u_add (
      .a   (acc_q),
      .b   (b_opnd),
      .fmt (ex_fmt),
      .sum (lane_sum)
   );

   always_ff @(posedge clk) begin
      rd_q <= mem[rd_addr];
      if (ex_active && ex_op == OP_STORE) begin
         mem[ex_addr] <= acc_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         recv_q <= '0;
      end else if (ex_active) begin
         case (ex_op)
            OP_LOAD:   acc_q <= rd_q;
            OP_LDIMM:  acc_q <= imm;
            OP_ADD:    acc_q <= lane_sum;
            OP_ADDRCV: acc_q <= lane_sum;
            OP_AND:    acc_q <= acc_q & rd_q;
            OP_OR:     acc_q <= acc_q | rd_q;
            OP_XOR:    acc_q <= acc_q ^ rd_q;
            OP_HALVE:  if (ex_recv_sel) recv_q <= recv_in;
            default:   ;
         endcase
      end
   end

   assign acc_out = acc_q;

endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
   import simd_pe_pkg::*;
#(
   parameter int NUM_PE    = 8,
   parameter int WORD_W    = 64,
   parameter int MEM_DEPTH = 32,
   parameter int ADDR_W    = 11,
   parameter int OPND_W    = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     instr_valid,
   input  logic [3:0]               instr_op,
   input  logic [1:0]               instr_fmt,
   input  logic [ADDR_W-1:0]        instr_addr,
   input  logic [OPND_W-1:0]        instr_opnd,
   input  logic [WORD_W-1:0]        bcast_word,
   output logic [NUM_PE*WORD_W-1:0] acc_flat,
   output logic [NUM_PE-1:0]        mode_bits
);
   localparam int MEM_AW = $clog2(MEM_DEPTH);
   localparam int IDX_W  = $clog2(NUM_PE);

   if (NUM_PE < 2 || (NUM_PE & (NUM_PE - 1)) != 0) begin : g_bad_pe
      $error("simd_pe_array: NUM_PE must be a power of two of at least 2");
   end
   if (NUM_PE > WORD_W) begin : g_bad_mask
      $error("simd_pe_array: mode mask must fit in one broadcast word");
   end
   if ((MEM_DEPTH & (MEM_DEPTH - 1)) != 0 || MEM_AW > ADDR_W) begin : g_bad_mem
      $error("simd_pe_array: MEM_DEPTH must be a power of two addressable by ADDR_W");
   end
   if (OPND_W <= IDX_W) begin : g_bad_opnd
      $error("simd_pe_array: OPND_W must hold the element count");
   end

   if (MEM_AW < ADDR_W) begin : g_addr_sink
      logic unused_addr_hi;
      assign unused_addr_hi = ^instr_addr[ADDR_W-1:MEM_AW];
   end

   logic [3:0]        ex_op;
   logic [1:0]        ex_fmt;
   logic [MEM_AW-1:0] ex_addr;
   logic [OPND_W-1:0] ex_opnd;
   logic [WORD_W-1:0] ex_word;
   logic [NUM_PE-1:0] mode_q, keep_mask;
   logic [OPND_W-1:0] half_span;
   logic [WORD_W-1:0] acc_arr [NUM_PE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ex_op   <= OP_NOP;
         ex_fmt  <= '0;
         ex_addr <= '0;
         ex_opnd <= '0;
         ex_word <= '0;
      end else begin
         ex_op   <= instr_valid ? instr_op : OP_NOP;
         ex_fmt  <= instr_fmt;
         ex_addr <= instr_addr[MEM_AW-1:0];
         ex_opnd <= instr_opnd;
         ex_word <= bcast_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '1;
      end else if (ex_op == OP_SETMODE) begin
         mode_q <= ex_word[NUM_PE-1:0];
      end else if (ex_op == OP_CLRABOVE) begin
         mode_q <= mode_q & keep_mask;
      end
   end

   assign half_span = ex_opnd >> 1;

   for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
      localparam logic [OPND_W-1:0] IDX  = OPND_W'(i);
      localparam logic [OPND_W:0]   IDXW = (OPND_W+1)'(i);
      logic [OPND_W:0]   partner;
      logic              recv_sel;
      logic [WORD_W-1:0] recv_in;

      assign keep_mask[i] = IDX < ex_opnd;
      assign partner      = IDXW + {1'b0, half_span};
      assign recv_sel     = IDX < half_span;
      assign recv_in      = (partner < (OPND_W+1)'(NUM_PE)) ? acc_arr[partner[IDX_W-1:0]] : '0;

      pe_element #(
         .WORD_W    (WORD_W),
         .MEM_DEPTH (MEM_DEPTH),
         .MEM_AW    (MEM_AW)
      ) u_pe (
         .clk         (clk),
         .rst_n       (rst_n),
         .rd_addr     (instr_addr[MEM_AW-1:0]),
         .ex_active   (mode_q[i]),
         .ex_op       (ex_op),
         .ex_fmt      (ex_fmt),
         .ex_addr     (ex_addr),
         .ex_recv_sel (recv_sel),
         .recv_in     (recv_in),
         .imm         (ex_word),
         .acc_out     (acc_arr[i])
      );

      assign acc_flat[i*WORD_W +: WORD_W] = acc_arr[i];
   end

   assign mode_bits = mode_q;

endmodule

// File: rtl/simd_pe_array_chk.sv
module simd_pe_array_chk
   import simd_pe_pkg::*;
#(
   parameter int NUM_PE = 8,
   parameter int WORD_W = 64,
   parameter int OPND_W = 7
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     instr_valid,
   input logic [3:0]               instr_op,
   input logic [OPND_W-1:0]        instr_opnd,
   input logic [WORD_W-1:0]        bcast_word,
   input logic [NUM_PE*WORD_W-1:0] acc_flat,
   input logic [NUM_PE-1:0]        mode_bits
);
   logic [3:0]        c_op;
   logic [OPND_W-1:0] c_opnd;
   logic [NUM_PE-1:0] c_mask;
   logic              acc_writer, mode_writer;
   logic              unused_word_bits;

   assign unused_word_bits = ^bcast_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_op   <= OP_NOP;
         c_opnd <= '0;
         c_mask <= '0;
      end else begin
         c_op   <= instr_valid ? instr_op : OP_NOP;
         c_opnd <= instr_opnd;
         c_mask <= bcast_word[NUM_PE-1:0];
      end
   end

   assign acc_writer  = c_op inside {OP_LOAD, OP_ADD, OP_AND, OP_OR, OP_XOR, OP_ADDRCV, OP_LDIMM};
   assign mode_writer = c_op inside {OP_SETMODE, OP_CLRABOVE};

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (acc_flat == '0 && mode_bits == '1));

   assert_acc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_writer |=> $stable(acc_flat));

   assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_writer |=> $stable(mode_bits));

   assert_setmode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (c_op == OP_SETMODE) |=> (mode_bits == $past(c_mask)));

   assert_clr_no_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (c_op == OP_CLRABOVE) |=> ((mode_bits & ~$past(mode_bits)) == '0));

   for (genvar i = 0; i < NUM_PE; i++) begin : g_elem
      assert_clr_above_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (c_op == OP_CLRABOVE && c_opnd <= OPND_W'(i)) |=> !mode_bits[i]);

      assert_inactive_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !mode_bits[i] |=> $stable(acc_flat[i*WORD_W +: WORD_W]));
   end

endmodule

bind simd_pe_array simd_pe_array_chk #(
   .NUM_PE (NUM_PE),
   .WORD_W (WORD_W),
   .OPND_W (OPND_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr_op    (instr_op),
   .instr_opnd  (instr_opnd),
   .bcast_word  (bcast_word),
   .acc_flat    (acc_flat),
   .mode_bits   (mode_bits)
);

// File: tb/simd_pe_array_tb.sv
`timescale 1ns/1ps
module simd_pe_array_tb;
   localparam int N  = 8;
   localparam int W  = 64;
   localparam int D  = 32;
   localparam int AW = 11;
   localparam int OW = 7;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            instr_valid = 1'b0;
   logic [3:0]      instr_op = '0;
   logic [1:0]      instr_fmt = '0;
   logic [AW-1:0]   instr_addr = '0;
   logic [OW-1:0]   instr_opnd = '0;
   logic [W-1:0]    bcast_word = '0;
   logic [N*W-1:0]  acc_flat;
   logic [N-1:0]    mode_bits;

   always #2.5 clk = ~clk;

   simd_pe_array #(.NUM_PE(N), .WORD_W(W), .MEM_DEPTH(D), .ADDR_W(AW), .OPND_W(OW)) u_dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
      .instr_fmt(instr_fmt), .instr_addr(instr_addr), .instr_opnd(instr_opnd),
      .bcast_word(bcast_word), .acc_flat(acc_flat), .mode_bits(mode_bits)
   );

   int n_cmp = 0;
   int n_bad = 0;

   logic [W-1:0] m_mem  [N][D];
   logic [W-1:0] m_acc  [N];
   logic [W-1:0] m_recv [N];
   logic [N-1:0] m_mode;

   function automatic logic [W-1:0] lane_sum(logic [W-1:0] a, logic [W-1:0] b, int f);
      logic [W-1:0] r;
      if (f == 1) begin
         r[31:0]  = a[31:0] + b[31:0];
         r[63:32] = a[63:32] + b[63:32];
      end else if (f == 2) begin
         for (int k = 0; k < 8; k++) r[k*8 +: 8] = a[k*8 +: 8] + b[k*8 +: 8];
      end else begin
         r = a + b;
      end
      return r;
   endfunction

   task automatic check_word(string tag, int idx, logic [W-1:0] got, logic [W-1:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s elem %0d acc got %h exp %h", tag, idx, got, exp);
      end
   endtask

   task automatic check_state(string tag);
      for (int i = 0; i < N; i++) check_word(tag, i, acc_flat[i*W +: W], m_acc[i]);
      n_cmp++;
      if (mode_bits !== m_mode) begin
         n_bad++;
         $display("FAIL %s mode got %b exp %b", tag, mode_bits, m_mode);
      end
   endtask

   task automatic step_model(int op, int f, int a, int o, logic [W-1:0] w);
      logic [W-1:0] nacc [N];
      int ai;
      int hs;
      ai = a % D;
      hs = o / 2;
      for (int i = 0; i < N; i++) begin
         nacc[i] = m_acc[i];
         if (m_mode[i]) begin
            case (op)
               1:  nacc[i] = m_mem[i][ai];
               2:  m_mem[i][ai] = m_acc[i];
               3:  nacc[i] = lane_sum(m_acc[i], m_mem[i][ai], f);
               4:  nacc[i] = m_acc[i] & m_mem[i][ai];
               5:  nacc[i] = m_acc[i] | m_mem[i][ai];
               6:  nacc[i] = m_acc[i] ^ m_mem[i][ai];
               9:  if (i < hs && i + hs < N) m_recv[i] = m_acc[i + hs];
               10: nacc[i] = lane_sum(m_acc[i], m_recv[i], f);
               11: nacc[i] = w;
               default: ;
            endcase
         end
      end
      for (int i = 0; i < N; i++) m_acc[i] = nacc[i];
      if (op == 7) m_mode = w[N-1:0];
      if (op == 8) for (int i = 0; i < N; i++) if (i >= o) m_mode[i] = 1'b0;
   endtask

   task automatic issue_v(bit vld, int op, int f, int a, int o, logic [W-1:0] w, string tag);
      @(negedge clk);
      instr_valid = vld;
      instr_op    = 4'(op);
      instr_fmt   = 2'(f);
      instr_addr  = AW'(a);
      instr_opnd  = OW'(o);
      bcast_word  = w;
      @(negedge clk);
      instr_valid = 1'b0;
      instr_op    = '0;
      check_state("R2 not-yet-due");
      @(negedge clk);
      if (vld) step_model(op, f, a, o, w);
      check_state(tag);
   endtask

   task automatic issue(int op, int f, int a, int o, logic [W-1:0] w, string tag);
      issue_v(1'b1, op, f, a, o, w, tag);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired got running exp finished");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_acc[i]  = '0;
         m_recv[i] = '0;
      end
      m_mode = '1;
      repeat (3) @(negedge clk);
      check_state("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1 after reset");

      // R3: fill each element's memory with distinct immediates
      for (int e = 0; e < N; e++) begin
         issue(7, 0, 0, 0, W'(1) << e, "R7 onehot");
         for (int a = 0; a < 16; a++) begin
            issue(11, 0, 0, 0, {$urandom, $urandom}, "R3 immediate");
            issue(2, 0, a, 0, '0, "R3 store");
         end
      end
      issue(7, 0, 0, 0, W'(8'hFF), "R7 all on");

      // R5: vector add A(base) = B(base+1) + C(base+2) in each format
      for (int f = 0; f < 4; f++) begin
         issue(1, 0, f*3 + 1, 0, '0, "R3 load");
         issue(3, f, f*3 + 2, 0, '0, "R5 lane add");
         issue(2, 0, f*3, 0, '0, "R3 store sum");
      end

      // R4: masked elements keep state
      issue(7, 0, 0, 0, W'(8'hA5), "R7 pattern");
      issue(1, 0, 1, 0, '0, "R4 masked load");
      issue(3, 2, 2, 0, '0, "R4 masked add");
      issue(2, 0, 12, 0, '0, "R4 masked store");
      issue(7, 0, 0, 0, W'(8'hFF), "R7 all on");
      issue(8, 0, 0, 5, '0, "R8 clear above 5");
      issue(8, 0, 0, 7, '0, "R8 no set");
      issue(1, 0, 4, 0, '0, "R4 short load");
      issue(3, 1, 5, 0, '0, "R4 short add");
      issue(2, 0, 13, 0, '0, "R4 short store");

      // R6: logic ops
      issue(7, 0, 0, 0, W'(8'hFF), "R7 all on");
      issue(1, 0, 7, 0, '0, "R3 load");
      issue(4, 0, 8, 0, '0, "R6 and");
      issue(5, 0, 9, 0, '0, "R6 or");
      issue(6, 0, 10, 0, '0, "R6 xor");
      issue(2, 0, 14, 0, '0, "R3 store");

      // R10: ignored opcodes and invalid cycles
      for (int op = 12; op < 16; op++) issue(op, 0, 3, 2, W'(8'h0F), "R10 undefined op");
      issue(0, 0, 3, 0, '0, "R10 nop");
      issue_v(1'b0, 3, 0, 3, 0, '0, "R10 valid low add");
      issue_v(1'b0, 7, 0, 0, 0, '0, "R10 valid low setmode");

      // R9: halving reductions
      for (int f = 0; f < 3; f += 2) begin
         issue(7, 0, 0, 0, W'(8'hFF), "R7 all on");
         issue(1, 0, 3, 0, '0, "R3 load");
         for (int s = N; s >= 2; s = s / 2) begin
            issue(9, 0, 0, s, '0, "R9 halve");
            issue(10, f, 0, 0, '0, "R9 add recv");
         end
         issue(2, 0, 15, 0, '0, "R9 store total");
      end
      issue(7, 0, 0, 0, W'(8'hFD), "R7 pattern");
      issue(1, 0, 6, 0, '0, "R3 load");
      issue(9, 0, 0, 8, '0, "R9 halve masked receiver");
      issue(10, 0, 0, 0, '0, "R9 add recv masked");
      issue(7, 0, 0, 0, W'(8'hFF), "R7 all on");
      issue(10, 0, 0, 0, '0, "R9 recv kept by inactive");

      // R3: read back every written word of every element
      for (int a = 0; a < 16; a++) issue(1, 0, a, 0, '0, "R3 readback");

      summary();
      $finish;
   end

endmodule